// File: doc/BRIEF.md
# Byte ALU with Selective Status Flags

This block is the arithmetic and logic stage of a small 8-bit datapath. It takes two byte operands, `opnd_a` and `opnd_b`, and a 4-bit operation code. It returns the byte result at once, on a combinational path, together with a write-back enable that tells the register file whether the destination should be written. The second operand may come from a register or from an immediate field; that choice is made outside the block.

A six-bit status register sits beside the datapath. On each clock edge where `exec_en` is high, it takes the flags that the chosen operation defines. Every operation updates its own subset of the flags and leaves the rest as they were. This lets software chain byte operations into wider ones:

- Add-with-carry and subtract-with-carry consume the stored carry.
- Compare-with-carry and subtract-with-carry can only keep a zero flag that is already set; they never set it anew.
- Compares and the test operation update flags without writing a result.

The flag register is the only state in the block, so there is no sequencer. It has two named conditions:

- **HOLD**: `exec_en` is low, or the operation code is the reserved one. The flags keep their value.
- **UPDATE**: `exec_en` is high with a defined code. The flags are merged on the next edge.

An asynchronous active-low reset clears the flag register.

Top module: `alu8_flags`

## Requirements
- R1: `flags_q` is ordered {H,S,V,N,Z,C} from bit 5 down to bit 0, and it is all zero after reset.
- R2: Codes 0 (add) and 1 (add with carry) return a+b, or a+b+C for code 1. C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, and Z is set for a zero result.
- R3: Codes 2 (subtract) and 3 (subtract with carry) return a-b, or a-b-C for code 3. C is set when the unsigned subtrahend (plus carry) exceeds a, H is the borrow out of bit 3, and V is signed overflow.
- R4: For codes 3 and 13, Z after the operation is 1 only when the result is zero and Z was already 1.
- R5: Codes 12 (compare, a-b) and 13 (compare with carry, a-b-C) set H, S, V, N, Z and C as subtraction does. They, and code 14 (test, a&a), hold `wr_en` low.
- R6: Codes 6 (AND), 7 (OR), 8 (XOR) and 14 (test) return the bitwise result and clear V. H and C keep their previous values.
- R7: Code 9 clears in a the bits set in b (a & ~b). Code 10 returns ~a. Both clear V and keep H and C.
- R8: Code 11 returns 0x00-a, so 0x80 stays 0x80. C is set when a is nonzero, H when the low nibble of a is nonzero, and V only for 0x80.
- R9: Codes 4 (increment) and 5 (decrement) return a+1 and a-1 modulo 256. V is set only for an operand of 0x7F (increment) or 0x80 (decrement). H and C keep their previous values.
- R10: After every update, S equals N xor V, and N equals bit 7 of the result.
- R11: With `exec_en` low, `wr_en` is 0 and the flags hold. Code 15 returns 0x00, never writes and changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| exec_en | input | 1 | Execute strobe: the operation takes effect this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| opnd_a | input | 8 | Destination operand |
| opnd_b | input | 8 | Source operand or immediate mask |
| result | output | 8 | Combinational result |
| wr_en | output | 1 | Write the result back to the destination |
| flags_q | output | 6 | Registered flags {H,S,V,N,Z,C} |

## Verification
The assertions check, on every cycle, the properties that relate the flag register to its own history and to the port values:

- S always equals N xor V.
- N follows bit 7 of any written result.
- The flags hold while the strobe is low.
- Increment and decrement leave H and C alone.
- Logic operations clear V.
- Compares never write.
- The chained zero flag is never set anew.
- Negating 0x80 returns 0x80.

Only the bench scenarios can show the numeric correctness of each flag. They compare every cycle against a reference model: carry and half carry at the nibble and byte boundaries, borrow in chained subtraction and comparison, and multi-byte equality through the sticky zero flag.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_INC  = 4'd4,
        OP_DEC  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_CLRM = 4'd9,
        OP_COM  = 4'd10,
        OP_NEG  = 4'd11,
        OP_CMP  = 4'd12,
        OP_CPC  = 4'd13,
        OP_TST  = 4'd14,
        OP_NONE = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

    localparam int FLAG_W = $bits(alu_flags_t);

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         co,
    output logic         hc,
    output logic         ov
);
    localparam int HW = W / 2;

    logic [W-1:0] bx;
    logic         cx;
    logic [W:0]   full;
    logic [HW:0]  half;

    always_comb begin
        bx   = sub ? ~b : b;
        cx   = sub ? ~cin : cin;
        full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cx};
        half = {1'b0, a[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, cx};
        r    = full[W-1:0];
        // for subtraction a set carry means no borrow, so invert it
        co   = full[W] ^ sub;
        hc   = half[HW] ^ sub;
        ov   = (a[W-1] == bx[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r
);
    always_comb begin
        unique case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_CLRM: r = a & ~b;
            OP_COM:  r = ~a;
            OP_TST:  r = a & a;
            default: r = '0;
        endcase
    end
endmodule

// File: rtl/alu8_flagmerge.sv
module alu8_flagmerge
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  alu_flags_t   cur,
    input  logic [W-1:0] r,
    input  logic         co,
    input  logic         hc,
    input  logic         ov,
    output alu_flags_t   nxt
);
    logic zr;

    always_comb begin
        zr  = (r == '0);
        nxt = cur;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_NEG, OP_CMP: begin
                nxt.h = hc;
                nxt.v = ov;
                nxt.c = co;
                nxt.n = r[W-1];
                nxt.z = zr;
            end
            OP_SBC, OP_CPC: begin
                nxt.h = hc;
                nxt.v = ov;
                nxt.c = co;
                nxt.n = r[W-1];
                nxt.z = zr & cur.z;
            end
            OP_INC, OP_DEC: begin
                nxt.v = ov;
                nxt.n = r[W-1];
                nxt.z = zr;
            end
            OP_AND, OP_OR, OP_XOR, OP_CLRM, OP_COM, OP_TST: begin
                nxt.v = 1'b0;
                nxt.n = r[W-1];
                nxt.z = zr;
            end
            OP_NONE: nxt = cur;
        endcase
        if (op != OP_NONE)
            nxt.s = nxt.n ^ nxt.v;
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic [3:0]        op_sel,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    output logic [W-1:0]      result,
    output logic              wr_en,
    output logic [FLAG_W-1:0] flags_q
);
    alu_op_e    op;
    alu_flags_t flags_r;
    alu_flags_t flags_nxt;

    logic [W-1:0] as_a, as_b, as_r, lg_r;
    logic         as_cin, as_sub, as_co, as_hc, as_ov;
    logic         is_arith;

    assign op = alu_op_e'(op_sel);

    // operand steering for the shared adder/subtractor
    always_comb begin
        as_a     = opnd_a;
        as_b     = opnd_b;
        as_cin   = 1'b0;
        as_sub   = 1'b0;
        is_arith = 1'b1;
        unique case (op)
            OP_ADD:         ;
            OP_ADC:         as_cin = flags_r.c;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC, OP_CPC: begin as_sub = 1'b1; as_cin = flags_r.c; end
            OP_INC:         as_b = {{(W-1){1'b0}}, 1'b1};
            OP_DEC:         begin as_b = {{(W-1){1'b0}}, 1'b1}; as_sub = 1'b1; end
            OP_NEG:         begin as_a = '0; as_b = opnd_a; as_sub = 1'b1; end
            default:        is_arith = 1'b0;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .r(as_r), .co(as_co), .hc(as_hc), .ov(as_ov)
    );

    alu8_logic #(.W(W)) u_logic (
        .op(op), .a(opnd_a), .b(opnd_b), .r(lg_r)
    );

    alu8_flagmerge #(.W(W)) u_merge (
        .op(op), .cur(flags_r), .r(result),
        .co(as_co), .hc(as_hc), .ov(as_ov), .nxt(flags_nxt)
    );

    // state register: HOLD unless strobed, else UPDATE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_r <= '0;
        else if (exec_en)
            flags_r <= flags_nxt;
    end

    // outputs
    always_comb begin
        result  = is_arith ? as_r : lg_r;
        wr_en   = exec_en && !(op inside {OP_CMP, OP_CPC, OP_TST, OP_NONE});
        flags_q = flags_r;
    end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_en,
    input logic [3:0]        op_sel,
    input logic [W-1:0]      opnd_a,
    input logic [W-1:0]      result,
    input logic              wr_en,
    input logic [FLAG_W-1:0] flags_q
);
    a_r10_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[4] == (flags_q[2] ^ flags_q[3]));

    a_r10_neg_msb: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && wr_en |=> flags_q[2] == $past(result[W-1]));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable(flags_q));

    a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && (op_sel inside {OP_CMP, OP_CPC, OP_TST}) |-> !wr_en);

    a_r9_keep_hc: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && (op_sel inside {OP_INC, OP_DEC}) |=>
        flags_q[5] == $past(flags_q[5]) && flags_q[0] == $past(flags_q[0]));

    a_r6_v_clear: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && (op_sel inside {OP_AND, OP_OR, OP_XOR, OP_CLRM, OP_COM, OP_TST})
        |=> !flags_q[3]);

    a_r4_z_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && (op_sel inside {OP_SBC, OP_CPC}) && !flags_q[1] |=> !flags_q[1]);

    a_r8_neg_min: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == OP_NEG && opnd_a == {1'b1, {(W-1){1'b0}}}
        |-> result == {1'b1, {(W-1){1'b0}}});
endmodule

bind alu8_flags alu8_flags_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
    .opnd_a(opnd_a), .result(result), .wr_en(wr_en), .flags_q(flags_q)
);

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_en = 1'b0;
    logic [3:0] op_sel = 4'd15;
    logic [7:0] opnd_a = '0, opnd_b = '0;
    logic [7:0] result;
    logic       wr_en;
    logic [5:0] flags_q;

    int  total = 0, bad = 0;
    bit  done = 0;
    bit [5:0] mflags = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_flags uut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .wr_en(wr_en),
        .flags_q(flags_q)
    );

    function automatic int sgn(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    function automatic void model(input bit en, input int op, input int a, input int b,
                                  input bit [5:0] f, output int res, output bit wr,
                                  output bit [5:0] nf);
        bit h, s, v, n, z, c;
        int ci, t, sv;
        {h, s, v, n, z, c} = f;
        res = 0;
        case (op)
            0, 1: begin
                ci = (op == 1) ? int'(c) : 0;
                t = a + b + ci; res = t & 255; c = t > 255;
                h = ((a & 15) + (b & 15) + ci) > 15;
                sv = sgn(a) + sgn(b) + ci; v = (sv > 127) || (sv < -128);
                z = res == 0;
            end
            2, 3, 12, 13: begin
                ci = (op == 3 || op == 13) ? int'(c) : 0;
                t = a - b - ci; res = t & 255; c = t < 0;
                h = ((a & 15) - (b & 15) - ci) < 0;
                sv = sgn(a) - sgn(b) - ci; v = (sv > 127) || (sv < -128);
                z = (op == 3 || op == 13) ? (res == 0 && z) : (res == 0);
            end
            11: begin
                res = (256 - a) & 255; c = a != 0; h = (a & 15) != 0;
                v = a == 128; z = res == 0;
            end
            4: begin res = (a + 1) & 255; v = a == 127; z = res == 0; end
            5: begin res = (a + 255) & 255; v = a == 128; z = res == 0; end
            6, 7, 8, 9, 10, 14: begin
                case (op)
                    6: res = a & b;
                    7: res = a | b;
                    8: res = a ^ b;
                    9: res = a & (255 - b);
                    10: res = 255 - a;
                    default: res = a;
                endcase
                v = 0; z = res == 0;
            end
            default: res = 0;
        endcase
        if (op != 15) begin
            n = res[7];
            s = n ^ v;
        end
        wr = en && !(op inside {12, 13, 14, 15});
        nf = en ? {h, s, v, n, z, c} : f;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input bit en, input int op, input int a, input int b, input string tag);
        int res; bit wr; bit [5:0] nf;
        @(negedge clk);
        exec_en = en; op_sel = op[3:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
        model(en, op, a, b, mflags, res, wr, nf);
        #1;
        check(tag, "result", int'(result), res);
        check(tag, "wr_en", int'(wr_en), int'(wr));
        @(posedge clk);
        #1;
        mflags = nf;
        check(tag, "flags", int'(flags_q), int'(mflags));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset flags", int'(flags_q), 0);
        @(negedge clk) rst_n = 1'b1;

        // R2 add, nibble carry, overflow, wrap
        run_op(1, 0, 8'h0F, 8'h01, "R2");
        run_op(1, 0, 8'h7F, 8'h01, "R2");
        run_op(1, 0, 8'hFF, 8'h01, "R2");
        run_op(1, 1, 8'h00, 8'h00, "R2");   // carry chained in
        run_op(1, 1, 8'h12, 8'h34, "R2");
        // R3 subtract and borrow chain
        run_op(1, 2, 8'h10, 8'h20, "R3");
        run_op(1, 3, 8'h05, 8'h01, "R3");
        run_op(1, 2, 8'h80, 8'h01, "R3");
        // R4 / R5 sticky zero across compares
        run_op(1, 12, 8'h05, 8'h05, "R5");
        run_op(1, 13, 8'h00, 8'h00, "R4");
        run_op(1, 12, 8'h05, 8'h04, "R5");
        run_op(1, 13, 8'h00, 8'h00, "R4");
        run_op(1, 2, 8'h01, 8'h02, "R3");
        run_op(1, 3, 8'h01, 8'h00, "R4");
        run_op(1, 14, 8'h80, 8'h00, "R5");
        // R6 / R7 logic
        run_op(1, 0, 8'h0F, 8'hF1, "R2");   // sets H and C before logic
        run_op(1, 6, 8'h35, 8'h01, "R6");
        run_op(1, 7, 8'hF0, 8'h0F, "R6");
        run_op(1, 8, 8'h2B, 8'h48, "R6");
        run_op(1, 14, 8'h00, 8'h77, "R6");
        run_op(1, 9, 8'h35, 8'h03, "R7");
        run_op(1, 10, 8'hFF, 8'h00, "R7");
        // R8 negate
        run_op(1, 11, 8'h80, 8'h00, "R8");
        run_op(1, 11, 8'h00, 8'h00, "R8");
        run_op(1, 11, 8'h10, 8'h00, "R8");
        run_op(1, 11, 8'h01, 8'h00, "R8");
        // R9 increment / decrement
        run_op(1, 4, 8'h7F, 8'h00, "R9");
        run_op(1, 5, 8'h80, 8'h00, "R9");
        run_op(1, 5, 8'h01, 8'h00, "R9");
        run_op(1, 4, 8'hFF, 8'h00, "R9");
        // R11 strobe low and reserved code
        run_op(0, 0, 8'hFF, 8'hFF, "R11");
        run_op(0, 12, 8'h01, 8'h02, "R11");
        run_op(1, 15, 8'h12, 8'h34, "R11");
        // R10 sweep: mixed operations against the model
        for (int i = 0; i < 400; i++)
            run_op(($urandom % 8) != 0, int'($urandom % 16),
                   int'($urandom % 256), int'($urandom % 256), "R10");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule